// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses for one SDRAM read or write burst. A column command loads a start column, a burst-length code, an ordering select and a read/write flag. The block then presents the first column at once. Each accepted data beat moves it to the next column of the chosen ordering. A flag marks the final column of a fixed-length burst. A full-page burst keeps running over the whole row until it is ended.

A new column command may arrive on any cycle, including in the middle of a burst. It drops the burst in progress and starts again from the new column. A stop input covers both a burst-stop and a precharge. It ends the burst at once. A single-write option turns every write into a one-beat burst. Reads still use the programmed length. Commands to the memory pins, bank and row handling, and data all stay outside this block.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While `rst` is high on a clock edge, `valid_o` and `last_o` are 0 after that edge.
- R2: A `cmd_i` pulse makes `valid_o` 1 after the edge, with `col_o` equal to `start_col_i`.
- R3: `blen_i` selects the burst length: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. The unused codes 3'b100, 3'b101 and 3'b110 give length 1.
- R4: With `ilv_i` = 0, beat k of a length-L burst (L of 2, 4 or 8) has the column ((start mod L) + k) mod L in its low log2(L) bits. The upper bits of the start column are kept.
- R5: With `ilv_i` = 1, beat k of a length-L burst has the start column's low log2(L) bits XORed with k. The upper bits are kept.
- R6: A full-page burst steps the whole column by one per beat and wraps from 255 to 0. `ilv_i` has no effect on it. It never raises `last_o` and runs until a stop or a new command.
- R7: `last_o` is 1 together with the final column of a fixed-length burst. When `adv_i` is high on that beat, `valid_o` is 0 after the edge.
- R8: While `valid_o` is 1 and `adv_i`, `cmd_i` and `stop_i` are low, `col_o`, `last_o` and `valid_o` hold their values.
- R9: With `stop_i` high and `cmd_i` low, `valid_o` is 0 after the edge. No further columns appear until the next command, even while `adv_i` stays high.
- R10: `cmd_i` takes priority over `stop_i` and `adv_i`. It restarts the sequence on any cycle, including back-to-back cycles and the middle of a burst.
- R11: With `one_wr_i` = 1, a write (`wr_i` = 1) is a one-beat burst whatever `blen_i` says. Reads, and writes with `one_wr_i` = 0, keep the programmed length.
- R12: `last_o` is never 1 while `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 1 | Column command: load the start column and settings |
| start_col_i | input | COL_W | Start column of the burst |
| blen_i | input | 3 | Burst-length code |
| ilv_i | input | 1 | 1 = interleaved ordering, 0 = sequential |
| wr_i | input | 1 | 1 = write burst, 0 = read burst |
| one_wr_i | input | 1 | Single-write option |
| stop_i | input | 1 | Burst stop or precharge: end the burst now |
| adv_i | input | 1 | The data beat for the current column is accepted |
| col_o | output | COL_W | Current column address |
| valid_o | output | 1 | `col_o` holds a live beat |
| last_o | output | 1 | `col_o` is the final beat of a fixed-length burst |

## Verification
A wrong beat counter or a wrong latched mask shows up at the ports as a wrong `col_o` on the first advance after the fault, so one cycle is enough to see it. A mismatch between the counter and the latched length shows up in two ways: `last_o` lands on the wrong beat, or `valid_o` drops early or late, within one burst of at most eight beats. A state that fails to clear on a command or a stop shows up as a stale column, or as `valid_o` staying high, on the very next edge. Full-page faults show up only at the wrap point, so that burst runs past column 255.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int BLC_W = 3;
  typedef logic [BLC_W-1:0] blen_code_t;

  localparam blen_code_t BLC_ONE   = 3'b000;
  localparam blen_code_t BLC_TWO   = 3'b001;
  localparam blen_code_t BLC_FOUR  = 3'b010;
  localparam blen_code_t BLC_EIGHT = 3'b011;
  localparam blen_code_t BLC_PAGE  = 3'b111;
endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  blen_code_t       code_i,
  input  logic             wr_i,
  input  logic             one_wr_i,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o
);
  logic force_one;
  assign force_one = wr_i & one_wr_i;

  always_comb begin
    mask_o = '0;
    page_o = 1'b0;
    if (!force_one) begin
      unique case (code_i)
        BLC_TWO:   mask_o = COL_W'(1);
        BLC_FOUR:  mask_o = COL_W'(3);
        BLC_EIGHT: mask_o = COL_W'(7);
        BLC_PAGE: begin
          mask_o = '1;
          page_o = 1'b1;
        end
        default:   mask_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/colgen_order.sv
module colgen_order #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] addr_o
);
  logic [COL_W-1:0] sum;
  assign sum = base_i + beat_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    logic wrap_bit;
    assign wrap_bit  = ilv_i ? (base_i[b] ^ beat_i[b]) : sum[b];
    assign addr_o[b] = mask_i[b] ? wrap_bit : base_i[b];
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       blen_i,
  input  logic             ilv_i,
  input  logic             wr_i,
  input  logic             one_wr_i,
  input  logic             stop_i,
  input  logic             adv_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] base_q, mask_q, beat_q;
  logic             ilv_q, page_q;

  logic [COL_W-1:0] new_mask;
  logic             new_page;
  logic [COL_W-1:0] beat_nx, addr_nx;

  colgen_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i  (blen_code_t'(blen_i)),
    .wr_i    (wr_i),
    .one_wr_i(one_wr_i),
    .mask_o  (new_mask),
    .page_o  (new_page)
  );

  assign beat_nx = beat_q + COL_W'(1);

  colgen_order #(.COL_W(COL_W)) u_ord (
    .base_i(base_q),
    .beat_i(beat_nx),
    .mask_i(mask_q),
    .ilv_i (ilv_q & ~page_q),
    .addr_o(addr_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      col_o   <= '0;
      base_q  <= '0;
      mask_q  <= '0;
      beat_q  <= '0;
      ilv_q   <= 1'b0;
      page_q  <= 1'b0;
    end else if (cmd_i) begin
      valid_o <= 1'b1;
      col_o   <= start_col_i;
      last_o  <= (new_mask == '0) && !new_page;
      base_q  <= start_col_i;
      mask_q  <= new_mask;
      page_q  <= new_page;
      ilv_q   <= ilv_i;
      beat_q  <= '0;
    end else if (stop_i) begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else if (valid_o && adv_i) begin
      if (last_o) begin
        valid_o <= 1'b0;
        last_o  <= 1'b0;
      end else begin
        beat_q <= beat_nx;
        col_o  <= addr_nx;
        last_o <= !page_q && (beat_nx == mask_q);
      end
    end
  end
endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             stop_i,
  input logic             adv_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!valid_o && !last_o));

  a_r2_load_start: assert property (@(posedge clk) disable iff (rst)
    cmd_i |=> (valid_o && col_o == $past(start_col_i)));

  a_r7_end_after_last: assert property (@(posedge clk) disable iff (rst)
    (valid_o && last_o && adv_i && !cmd_i) |=> !valid_o);

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !adv_i && !cmd_i && !stop_i) |=>
      (valid_o && $stable(col_o) && $stable(last_o)));

  a_r9_stop_ends: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !cmd_i) |=> !valid_o);

  a_r9_no_revival: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && !cmd_i) |=> !valid_o);

  a_r12_last_needs_valid: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);
endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_i      (cmd_i),
  .start_col_i(start_col_i),
  .stop_i     (stop_i),
  .adv_i      (adv_i),
  .col_o      (col_o),
  .valid_o    (valid_o),
  .last_o     (last_o)
);

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;
  localparam int COL_W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 13;

  // fields: [19:12] start, [11:9] code, [8] ilv, [7] wr, [6] one_wr, [5:0] beats
  localparam logic [19:0] VEC [NV] = '{
    {8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 6'd1},
    {8'h05, 3'd1, 1'b0, 1'b0, 1'b0, 6'd2},
    {8'h07, 3'd2, 1'b1, 1'b0, 1'b0, 6'd4},
    {8'h3e, 3'd3, 1'b0, 1'b0, 1'b0, 6'd8},
    {8'h3b, 3'd3, 1'b1, 1'b0, 1'b0, 6'd8},
    {8'hff, 3'd2, 1'b0, 1'b0, 1'b0, 6'd4},
    {8'h10, 3'd4, 1'b0, 1'b0, 1'b0, 6'd1},
    {8'h22, 3'd5, 1'b1, 1'b0, 1'b0, 6'd1},
    {8'h33, 3'd6, 1'b1, 1'b0, 1'b0, 6'd1},
    {8'h46, 3'd3, 1'b0, 1'b1, 1'b1, 6'd1},
    {8'h46, 3'd3, 1'b0, 1'b0, 1'b1, 6'd8},
    {8'h46, 3'd3, 1'b0, 1'b1, 1'b0, 6'd8},
    {8'h81, 3'd2, 1'b1, 1'b1, 1'b1, 6'd1}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmd_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       blen_i = '0;
  logic             ilv_i = 1'b0;
  logic             wr_i = 1'b0;
  logic             one_wr_i = 1'b0;
  logic             stop_i = 1'b0;
  logic             adv_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;

  int checks = 0;
  int errors = 0;

  sdram_burst_colgen #(.COL_W(COL_W)) u_dut (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Column of beat k in an L-beat burst (L = 1, 2, 4, 8), from the ordering rules
  function automatic int ref_col(input int st, input int len, input bit il, input int k);
    int blk;
    int off;
    blk = st - (st % len);
    off = st % len;
    if (il) return blk + (off ^ k);
    return blk + ((off + k) % len);
  endfunction

  task automatic issue(input int st, input int code, input bit il, input bit wr, input bit one);
    cmd_i = 1'b1;
    start_col_i = COL_W'(st);
    blen_i = 3'(code);
    ilv_i = il;
    wr_i = wr;
    one_wr_i = one;
    tick();
    cmd_i = 1'b0;
  endtask

  task automatic run_fixed(input int st, input int code, input bit il, input bit wr,
                           input bit one, input int len, input string tag);
    adv_i = 1'b1;
    issue(st, code, il, wr, one);
    for (int k = 0; k < len; k++) begin
      chk(valid_o === 1'b1, {tag, " valid"}, int'(valid_o), 1);
      chk(col_o === COL_W'(ref_col(st, len, il, k)), {tag, " col"}, int'(col_o),
          ref_col(st, len, il, k));
      chk(last_o === (k == len - 1), {tag, " R7 last"}, int'(last_o), int'(k == len - 1));
      tick();
    end
    chk(valid_o === 1'b0, {tag, " R7 end"}, int'(valid_o), 0);
    adv_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick();
    tick();
    // R1: reset state
    chk(valid_o === 1'b0 && last_o === 1'b0, "R1 reset", int'({valid_o, last_o}), 0);
    rst = 1'b0;
    tick();

    // Table walk: R2 R3 R4 R5 R11
    for (int v = 0; v < NV; v++) begin
      run_fixed(int'(VEC[v][19:12]), int'(VEC[v][11:9]), VEC[v][8], VEC[v][7], VEC[v][6],
                int'(VEC[v][5:0]), "R3 R11 table");
    end

    // Sweep: every start, lengths 1/2/4/8, both orderings (R4 R5)
    for (int code = 0; code < 4; code++) begin
      for (int il = 0; il < 2; il++) begin
        for (int st = 0; st < 256; st++) begin
          run_fixed(st, code, il[0], 1'b0, 1'b0, 1 << code, il ? "R5 sweep" : "R4 sweep");
        end
      end
    end

    // R6: full page, ilv ignored, wraps, never last
    adv_i = 1'b1;
    issue(8'hfa, 7, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 262; k++) begin
      chk(valid_o === 1'b1 && col_o === COL_W'((8'hfa + k) % 256), "R6 page col",
          int'(col_o), (8'hfa + k) % 256);
      chk(last_o === 1'b0, "R6 page no last", int'(last_o), 0);
      tick();
    end
    // R9: stop ends it, no revival while adv stays high
    stop_i = 1'b1;
    tick();
    stop_i = 1'b0;
    chk(valid_o === 1'b0 && last_o === 1'b0, "R9 stop", int'({valid_o, last_o}), 0);
    tick();
    tick();
    chk(valid_o === 1'b0, "R9 stays idle", int'(valid_o), 0);

    // R9: stop in a fixed burst
    issue(8'h20, 3, 1'b0, 1'b0, 1'b0);
    tick();
    stop_i = 1'b1;
    tick();
    stop_i = 1'b0;
    chk(valid_o === 1'b0, "R9 stop fixed", int'(valid_o), 0);
    adv_i = 1'b0;

    // R8: hold while adv low
    issue(8'h3e, 3, 1'b0, 1'b0, 1'b0);
    tick();
    tick();
    tick();
    chk(valid_o === 1'b1 && col_o === 8'h3e && last_o === 1'b0, "R8 hold", int'(col_o), 8'h3e);
    adv_i = 1'b1;
    tick();
    adv_i = 1'b0;
    chk(col_o === 8'h3f, "R8 advance", int'(col_o), 8'h3f);
    tick();
    tick();
    chk(col_o === 8'h3f && valid_o === 1'b1, "R8 hold again", int'(col_o), 8'h3f);

    // R10: restart mid-burst, then into interleaved 4-beat
    adv_i = 1'b1;
    issue(8'h10, 3, 1'b0, 1'b0, 1'b0);
    tick();
    issue(8'h95, 2, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      chk(col_o === COL_W'(ref_col(8'h95, 4, 1'b1, k)), "R10 restart col", int'(col_o),
          ref_col(8'h95, 4, 1'b1, k));
      chk(last_o === (k == 3), "R10 restart last", int'(last_o), int'(k == 3));
      tick();
    end

    // R10: back-to-back commands, and command beating stop
    for (int k = 0; k < 5; k++) begin
      issue(8'h40 + 9 * k, 3, 1'b0, 1'b0, 1'b0);
      chk(col_o === COL_W'(8'h40 + 9 * k) && valid_o === 1'b1, "R10 back to back",
          int'(col_o), 8'h40 + 9 * k);
    end
    stop_i = 1'b1;
    issue(8'hc3, 1, 1'b0, 1'b0, 1'b0);
    stop_i = 1'b0;
    chk(valid_o === 1'b1 && col_o === 8'hc3, "R10 cmd over stop", int'(col_o), 8'hc3);

    // R1: reset mid-burst
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk(valid_o === 1'b0 && last_o === 1'b0, "R1 mid reset", int'({valid_o, last_o}), 0);
    tick();
    // R12: idle means no last
    chk(last_o === 1'b0, "R12 idle last", int'(last_o), 0);
    adv_i = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule